// File: doc/BRIEF.md
# Register Frame Call Unit

This unit sits beside a register file and turns the operand specifiers of each instruction into register-file addresses. The addresses are built from three movable frame pointers and one global window. The three pointers are Open, Active and Return. Each pointer is an 8-bit frame base that is joined with a 4-bit offset, giving a 12-bit address. The global window joins a 4-bit immediate from the instruction with the offset, so it reaches only the lowest 256 locations. A 7-bit specifier whose top bit is set is not a register reference: it passes a 6-bit functional code to the datapath instead.

Every instruction also carries a 3-bit call opcode, which the unit executes in the same cycle. The opcodes are no-op, open, call, open-call, tail-open, tail-call and return. Open takes the lowest free frame from an allocation bitmap. Call saves the caller's linkage on an internal stack. Tail-call hands the current linkage on without pushing. Return pops the stack and releases the callee frame.

Sources are addressed with the pointers as they stood before the call opcode acts. The destination is addressed with the pointers after it, so a value returned by a callee lands in the caller's frame. The unit raises a storage-full trap or a sequence-error trap. A trapped or unissued instruction leaves all state untouched.

Top module: `regframe_callunit`

## Requirements
- R1: A register specifier holds a 2-bit frame select in bits [5:4] (0 Open, 1 Active, 2 Return) and a 4-bit offset in bits [3:0]. Its address is {frame base, offset}.
- R2: Frame select 3 (global) gives the address {4'b0, imm, offset}, which lies in locations 0 to 255.
- R3: A 7-bit specifier with bit 6 set raises its functional flag and outputs bits [5:0] as the functional code.
- R4: The left and right addresses use the pointers as they stand before this instruction's call opcode. The destination address uses the pointers after it.
- R5: Open (code 1) and tail-open (code 4) mark the lowest-numbered free frame as busy and load its number into Open. Frame 0 is the root frame and is never free.
- R6: Call (code 2) pushes {Return, Active, ret_pc_in, ret_dst_in}, then sets Return to the old Active and Active to Open. Open-call (code 3) first allocates as in R5 and then calls into the new frame. Return (code 6) pops the stack. It restores Active and Return from the popped entry, sets Open to the restored Active, and frees the callee frame unless that frame is frame 0 or is the restored frame. ret_pc and ret_dst always show the top stack entry, or zero when the stack is empty.
- R7: Tail-call (code 5) sets Active to Open and leaves Return and the stack unchanged. It frees the old Active frame unless that frame equals Open or is frame 0.
- R8: The destination specifier 7'h7E takes the current ret_dst in its place before decoding. The current ret_dst is read before the opcode acts.
- R9: trap_full rises when an allocating opcode finds no free frame, or when a pushing opcode finds the stack holding DEPTH entries.
- R10: trap_seq rises for opcode 7. It also rises for a return when the stack is empty, and for a return when the previous accepted instruction was also a return.
- R11: While ins_valid is low, or while either trap is raised, no pointer, bitmap, stack or return-sequence state changes, and no trap is reported while ins_valid is low.
- R12: After reset all three pointers are 0, only frame 0 is busy, the stack is empty, and ret_pc and ret_dst read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction issues this cycle |
| chop | input | 3 | Call opcode |
| left_spec | input | 6 | Left source specifier (always a register) |
| right_spec | input | 7 | Right source specifier |
| dst_spec | input | 7 | Destination specifier |
| imm | input | 4 | Global-window immediate |
| ret_dst_in | input | 7 | Return destination saved by a call |
| ret_pc_in | input | 23 | Return PC saved by a call |
| left_addr | output | 12 | Left register address |
| right_addr | output | 12 | Right register address |
| right_is_func | output | 1 | Right specifier is functional |
| right_fcode | output | 6 | Right functional code |
| dst_addr | output | 12 | Destination register address |
| dst_is_func | output | 1 | Destination is functional |
| dst_fcode | output | 6 | Destination functional code |
| ret_pc | output | 23 | Top-of-stack return PC |
| ret_dst | output | 7 | Top-of-stack return destination |
| trap_full | output | 1 | Frame or stack storage exhausted |
| trap_seq | output | 1 | Illegal call sequence |

## Verification
In one cycle the unit decodes operand addresses and also moves the frame pointers. The hazard is that the source and destination paths see different pointer states. Open-call and return instructions are issued with the same frame select on the left source and on the destination, and the bench expects the left address from the old pointers and the destination address from the new ones. The save-destination substitution is exercised on return instructions: the substituted field must be read from the stack before the pop but decoded with the caller's restored pointers.

// File: rtl/regframe_callunit.sv
module regframe_callunit #(
  parameter int BASE_W  = 8,
  parameter int OFF_W   = 4,
  parameter int PC_W    = 23,
  parameter int NFRAMES = 16,
  parameter int DEPTH   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ins_valid,
  input  logic [2:0]                chop,
  input  logic [OFF_W+1:0]          left_spec,
  input  logic [OFF_W+2:0]          right_spec,
  input  logic [OFF_W+2:0]          dst_spec,
  input  logic [OFF_W-1:0]          imm,
  input  logic [OFF_W+2:0]          ret_dst_in,
  input  logic [PC_W-1:0]           ret_pc_in,
  output logic [BASE_W+OFF_W-1:0]   left_addr,
  output logic [BASE_W+OFF_W-1:0]   right_addr,
  output logic                      right_is_func,
  output logic [OFF_W+1:0]          right_fcode,
  output logic [BASE_W+OFF_W-1:0]   dst_addr,
  output logic                      dst_is_func,
  output logic [OFF_W+1:0]          dst_fcode,
  output logic [PC_W-1:0]           ret_pc,
  output logic [OFF_W+2:0]          ret_dst,
  output logic                      trap_full,
  output logic                      trap_seq
);
  localparam int AW  = BASE_W + OFF_W;
  localparam int SW  = OFF_W + 3;
  localparam int FW  = $clog2(NFRAMES);
  localparam int IW  = $clog2(DEPTH);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [2:0] OP_OPEN = 3'd1, OP_CALL = 3'd2, OP_OCALL = 3'd3,
                         OP_TOPEN = 3'd4, OP_TCALL = 3'd5, OP_RET = 3'd6, OP_BAD = 3'd7;
  localparam logic [SW-1:0] USE_RET = {1'b1, {(OFF_W+1){1'b1}}, 1'b0};

  logic [BASE_W-1:0] o_q, a_q, r_q, o_n, a_n, r_n;
  logic [NFRAMES-1:0] busy_q, busy_n;
  logic [SPW-1:0] sp_q;
  logic prev_ret_q;

  logic [BASE_W-1:0] stk_r [DEPTH];
  logic [BASE_W-1:0] stk_a [DEPTH];
  logic [PC_W-1:0]   stk_pc[DEPTH];
  logic [SW-1:0]     stk_dst[DEPTH];

  logic have_top;
  logic [IW-1:0] top_i, push_i;
  logic [BASE_W-1:0] top_a, top_r;
  logic [FW-1:0] free_i;
  logic [BASE_W-1:0] free_base;
  logic free_ok, wants_alloc, wants_push, is_ret, go;
  logic [SW-1:0] dst_eff;

  assign have_top = sp_q != '0;
  assign top_i    = IW'(sp_q - 1'b1);
  assign push_i   = IW'(sp_q);
  assign top_a    = have_top ? stk_a[top_i]   : '0;
  assign top_r    = have_top ? stk_r[top_i]   : '0;
  assign ret_pc   = have_top ? stk_pc[top_i]  : '0;
  assign ret_dst  = have_top ? stk_dst[top_i] : '0;

  always_comb begin
    free_ok = 1'b0;
    free_i  = '0;
    for (int i = NFRAMES - 1; i >= 1; i--)
      if (!busy_q[i]) begin
        free_ok = 1'b1;
        free_i  = FW'(i);
      end
  end
  assign free_base = BASE_W'(free_i);

  assign wants_alloc = (chop == OP_OPEN) || (chop == OP_OCALL) || (chop == OP_TOPEN);
  assign wants_push  = (chop == OP_CALL) || (chop == OP_OCALL);
  assign is_ret      = chop == OP_RET;

  assign trap_full = ins_valid && ((wants_alloc && !free_ok) || (wants_push && sp_q == SPW'(DEPTH)));
  assign trap_seq  = ins_valid && ((chop == OP_BAD) || (is_ret && (!have_top || prev_ret_q)));
  assign go        = ins_valid && !trap_full && !trap_seq;

  always_comb begin
    o_n = o_q; a_n = a_q; r_n = r_q; busy_n = busy_q;
    if (go) begin
      unique case (chop)
        OP_OPEN, OP_TOPEN: begin
          o_n = free_base;
          busy_n[free_i] = 1'b1;
        end
        OP_CALL: begin
          r_n = a_q;
          a_n = o_q;
        end
        OP_OCALL: begin
          o_n = free_base;
          busy_n[free_i] = 1'b1;
          r_n = a_q;
          a_n = free_base;
        end
        OP_TCALL: begin
          if (a_q != o_q && a_q != '0) busy_n[FW'(a_q)] = 1'b0;
          a_n = o_q;
        end
        OP_RET: begin
          if (a_q != '0 && a_q != top_a) busy_n[FW'(a_q)] = 1'b0;
          a_n = top_a;
          r_n = top_r;
          o_n = top_a;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_q <= '0; a_q <= '0; r_q <= '0;
      busy_q <= NFRAMES'(1);
      sp_q <= '0;
      prev_ret_q <= 1'b0;
    end else begin
      o_q <= o_n; a_q <= a_n; r_q <= r_n;
      busy_q <= busy_n;
      if (go) begin
        prev_ret_q <= is_ret;
        if (wants_push) sp_q <= sp_q + 1'b1;
        else if (is_ret) sp_q <= sp_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (rst_n && go && wants_push) begin
      stk_r[push_i]   <= r_q;
      stk_a[push_i]   <= a_q;
      stk_pc[push_i]  <= ret_pc_in;
      stk_dst[push_i] <= ret_dst_in;
    end

  function automatic logic [AW-1:0] frame_addr(input logic [1:0] sel, input logic [OFF_W-1:0] off,
      input logic [BASE_W-1:0] o, input logic [BASE_W-1:0] a, input logic [BASE_W-1:0] r,
      input logic [OFF_W-1:0] k);
    case (sel)
      2'd0:    return {o, off};
      2'd1:    return {a, off};
      2'd2:    return {r, off};
      default: return {{(AW-2*OFF_W){1'b0}}, k, off};
    endcase
  endfunction

  assign left_addr  = frame_addr(left_spec[OFF_W+1:OFF_W], left_spec[OFF_W-1:0], o_q, a_q, r_q, imm);
  assign right_addr = frame_addr(right_spec[OFF_W+1:OFF_W], right_spec[OFF_W-1:0], o_q, a_q, r_q, imm);
  assign right_is_func = right_spec[SW-1];
  assign right_fcode   = right_spec[SW-2:0];

  assign dst_eff     = (dst_spec == USE_RET) ? ret_dst : dst_spec;
  assign dst_addr    = frame_addr(dst_eff[OFF_W+1:OFF_W], dst_eff[OFF_W-1:0], o_n, a_n, r_n, imm);
  assign dst_is_func = dst_eff[SW-1];
  assign dst_fcode   = dst_eff[SW-2:0];
endmodule

// File: rtl/regframe_callunit_chk.sv
module regframe_callunit_chk #(
  parameter int BASE_W = 8,
  parameter int OFF_W  = 4,
  parameter int PC_W   = 23
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ins_valid,
  input logic [2:0]              chop,
  input logic [OFF_W+1:0]        left_spec,
  input logic [OFF_W+2:0]        right_spec,
  input logic [OFF_W+2:0]        dst_spec,
  input logic [OFF_W+2:0]        ret_dst_in,
  input logic [PC_W-1:0]         ret_pc_in,
  input logic [BASE_W+OFF_W-1:0] left_addr,
  input logic [BASE_W+OFF_W-1:0] right_addr,
  input logic [BASE_W+OFF_W-1:0] dst_addr,
  input logic [PC_W-1:0]         ret_pc,
  input logic [OFF_W+2:0]        ret_dst,
  input logic                    trap_full,
  input logic                    trap_seq
);
  localparam int AW = BASE_W + OFF_W;
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  // R10
  ret_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ins_valid && chop == 3'd6 && $past(ins_valid && chop == 3'd6 && !trap_full && !trap_seq))
    |-> trap_seq);

  // R10
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && chop == 3'd7) |-> trap_seq);

  // R6
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && (chop == 3'd2 || chop == 3'd3) && !trap_full && !trap_seq)
    |=> (ret_pc == $past(ret_pc_in) && ret_dst == $past(ret_dst_in)));

  // R11
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_full || trap_seq || !ins_valid) |=> ($stable(ret_pc) && $stable(ret_dst)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |-> (!trap_full && !trap_seq));

  // R2
  global_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!right_spec[OFF_W+2] && right_spec[OFF_W+1:OFF_W] == 2'd3)
    |-> (right_addr[AW-1:2*OFF_W] == '0));

  // R4
  same_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chop == 3'd0 && !dst_spec[OFF_W+2] && dst_spec[OFF_W+1:0] == left_spec)
    |-> (dst_addr == left_addr));
endmodule

bind regframe_callunit regframe_callunit_chk #(.BASE_W(BASE_W), .OFF_W(OFF_W), .PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .chop(chop),
  .left_spec(left_spec), .right_spec(right_spec), .dst_spec(dst_spec),
  .ret_dst_in(ret_dst_in), .ret_pc_in(ret_pc_in),
  .left_addr(left_addr), .right_addr(right_addr), .dst_addr(dst_addr),
  .ret_pc(ret_pc), .ret_dst(ret_dst), .trap_full(trap_full), .trap_seq(trap_seq)
);

// File: tb/regframe_callunit_tb_top.sv
`timescale 1ns/100ps
module regframe_callunit_tb_top;
  localparam int NF = 16, DP = 8;

  logic clk = 1'b0, rst_n = 1'b0, ins_valid = 1'b0;
  logic [2:0] chop = '0;
  logic [5:0] left_spec = '0;
  logic [6:0] right_spec = '0, dst_spec = '0, ret_dst_in = '0;
  logic [3:0] imm = '0;
  logic [22:0] ret_pc_in = '0;
  logic [11:0] left_addr, right_addr, dst_addr;
  logic right_is_func, dst_is_func, trap_full, trap_seq;
  logic [5:0] right_fcode, dst_fcode;
  logic [22:0] ret_pc;
  logic [6:0] ret_dst;

  always #2.5 clk = ~clk;

  regframe_callunit #(.NFRAMES(NF), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .chop(chop),
    .left_spec(left_spec), .right_spec(right_spec), .dst_spec(dst_spec), .imm(imm),
    .ret_dst_in(ret_dst_in), .ret_pc_in(ret_pc_in),
    .left_addr(left_addr), .right_addr(right_addr), .right_is_func(right_is_func),
    .right_fcode(right_fcode), .dst_addr(dst_addr), .dst_is_func(dst_is_func),
    .dst_fcode(dst_fcode), .ret_pc(ret_pc), .ret_dst(ret_dst),
    .trap_full(trap_full), .trap_seq(trap_seq));

  int checks = 0, fails = 0;
  int mo, ma, mr, msp;
  bit mprev;
  bit mbusy[NF];
  int sr[DP], sa[DP], spc[DP], sdst[DP];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int eaddr(input logic [5:0] s, input logic [3:0] k, input int o, input int a, input int r);
    case (s[5:4])
      2'd0: return o * 16 + s[3:0];
      2'd1: return a * 16 + s[3:0];
      2'd2: return r * 16 + s[3:0];
      default: return k * 16 + s[3:0];
    endcase
  endfunction

  task automatic mreset();
    mo = 0; ma = 0; mr = 0; msp = 0; mprev = 0;
    foreach (mbusy[i]) mbusy[i] = (i == 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ins_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mreset();
  endtask

  task automatic step(input string tag, input bit v, input logic [2:0] op, input logic [5:0] l,
                      input logic [6:0] rs, input logic [6:0] ds, input logic [3:0] k,
                      input logic [6:0] rd, input int pc);
    int f, no, na, nr, ta, tr, tpc, tdst;
    bit alloc, push, isret, efull, eseq, go;
    logic [6:0] deff;
    @(negedge clk);
    ins_valid = v; chop = op; left_spec = l; right_spec = rs; dst_spec = ds; imm = k;
    ret_dst_in = rd; ret_pc_in = pc[22:0];
    #1;
    f = -1;
    for (int i = NF - 1; i >= 1; i--) if (!mbusy[i]) f = i;
    alloc = (op == 3'd1) || (op == 3'd3) || (op == 3'd4);
    push  = (op == 3'd2) || (op == 3'd3);
    isret = op == 3'd6;
    efull = v && ((alloc && f < 0) || (push && msp == DP));
    eseq  = v && ((op == 3'd7) || (isret && (msp == 0 || mprev)));
    go    = v && !efull && !eseq;
    ta   = msp > 0 ? sa[msp-1] : 0;
    tr   = msp > 0 ? sr[msp-1] : 0;
    tpc  = msp > 0 ? spc[msp-1] : 0;
    tdst = msp > 0 ? sdst[msp-1] : 0;
    no = mo; na = ma; nr = mr;
    if (go) begin
      case (op)
        3'd1, 3'd4: no = f;
        3'd2: begin nr = ma; na = mo; end
        3'd3: begin no = f; nr = ma; na = f; end
        3'd5: na = mo;
        3'd6: begin na = ta; nr = tr; no = ta; end
        default: ;
      endcase
    end
    chk(trap_full == efull, tag, "trap_full", trap_full, efull);
    chk(trap_seq == eseq, tag, "trap_seq", trap_seq, eseq);
    chk(ret_pc == tpc[22:0], tag, "ret_pc", ret_pc, tpc);
    chk(ret_dst == tdst[6:0], tag, "ret_dst", ret_dst, tdst);
    chk(left_addr == eaddr(l, k, mo, ma, mr), l[5:4] == 2'd3 ? "R2" : "R1", "left_addr",
        left_addr, eaddr(l, k, mo, ma, mr));
    if (rs[6]) begin
      chk(right_is_func && right_fcode == rs[5:0], "R3", "right_fcode", right_fcode, rs[5:0]);
    end else begin
      chk(!right_is_func && right_addr == eaddr(rs[5:0], k, mo, ma, mr),
          rs[5:4] == 2'd3 ? "R2" : "R1", "right_addr", right_addr, eaddr(rs[5:0], k, mo, ma, mr));
    end
    deff = (ds == 7'h7E) ? tdst[6:0] : ds;
    if (deff[6]) begin
      chk(dst_is_func && dst_fcode == deff[5:0], "R3", "dst_fcode", dst_fcode, deff[5:0]);
    end else begin
      chk(!dst_is_func && dst_addr == eaddr(deff[5:0], k, no, na, nr),
          ds == 7'h7E ? "R8" : "R4", "dst_addr", dst_addr, eaddr(deff[5:0], k, no, na, nr));
    end
    if (go) begin
      if (alloc) mbusy[f] = 1'b1;
      if (op == 3'd5 && ma != mo && ma != 0) mbusy[ma] = 1'b0;
      if (isret) begin
        if (ma != 0 && ma != ta) mbusy[ma] = 1'b0;
        msp--;
      end
      if (push) begin
        sr[msp] = mr; sa[msp] = ma; spc[msp] = pc & 32'h7FFFFF; sdst[msp] = rd; msp++;
      end
      mprev = isret;
      mo = no; ma = na; mr = nr;
    end
    @(posedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    step("R12", 1, 3'd0, 6'h17, 7'h25, 7'h1A, 4'h0, 7'h0, 0);
    // R5 open, R6 call, R5 open again: O=2, A=1, R=0
    step("R5", 1, 3'd1, 6'h02, 7'h02, 7'h02, 4'h0, 7'h0, 0);
    step("R6", 1, 3'd2, 6'h12, 7'h02, 7'h12, 4'h0, 7'h0B, 23'h100);
    step("R5", 1, 3'd1, 6'h03, 7'h03, 7'h03, 4'h0, 7'h0, 0);
    // R1 R2 sweep of every frame select, offset and immediate
    for (int s = 0; s < 64; s++)
      for (int k = 0; k < 16; k++)
        step("R1", 1, 3'd0, s[5:0], {1'b0, s[5:0]}, {1'b0, 6'(63 - s)}, k[3:0], 7'h0, 0);
    // R3 functional specifiers
    for (int s = 0; s < 64; s++)
      step("R3", 1, 3'd0, 6'h0, {1'b1, s[5:0]}, {1'b1, 6'(s ^ 21)}, 4'h0, 7'h0, 0);
    // R4 open-call: left sees old O, dest sees new O
    step("R4", 1, 3'd3, 6'h05, 7'h15, 7'h05, 4'h0, 7'h15, 23'h1234);
    // R8 return destination substituted and decoded in caller frame
    step("R8", 1, 3'd0, 6'h00, 7'h00, 7'h7E, 4'h0, 7'h0, 0);
    step("R8", 1, 3'd6, 6'h15, 7'h15, 7'h7E, 4'h0, 7'h0, 0);
    // R10 return directly after return
    step("R10", 1, 3'd6, 6'h10, 7'h10, 7'h10, 4'h0, 7'h0, 0);
    step("R11", 1, 3'd0, 6'h10, 7'h20, 7'h10, 4'h0, 7'h0, 0);
    step("R6", 1, 3'd6, 6'h10, 7'h20, 7'h7E, 4'h0, 7'h0, 0);
    // R10 return with empty stack, illegal opcode
    step("R10", 1, 3'd0, 6'h10, 7'h10, 7'h10, 4'h0, 7'h0, 0);
    step("R10", 1, 3'd6, 6'h10, 7'h10, 7'h10, 4'h0, 7'h0, 0);
    step("R10", 1, 3'd7, 6'h10, 7'h10, 7'h10, 4'h0, 7'h0, 0);
    // R11 unissued illegal opcode
    step("R11", 0, 3'd7, 6'h10, 7'h10, 7'h10, 4'h0, 7'h0, 0);
    // R7 tail call releases frame, stack depth kept
    step("R6", 1, 3'd3, 6'h00, 7'h00, 7'h10, 4'h0, 7'h2A, 23'h777);
    step("R7", 1, 3'd4, 6'h00, 7'h00, 7'h00, 4'h0, 7'h0, 0);
    step("R7", 1, 3'd5, 6'h10, 7'h10, 7'h10, 4'h0, 7'h0, 23'h555);
    step("R7", 1, 3'd1, 6'h00, 7'h00, 7'h00, 4'h0, 7'h0, 0);
    step("R7", 1, 3'd6, 6'h10, 7'h10, 7'h7E, 4'h0, 7'h0, 0);
    // R9 stack full
    for (int i = 0; i < DP + 2; i++)
      step("R9", 1, 3'd3, 6'h10, 7'h20, 7'h10, 4'h0, 7'(i + 3), 1000 + i);
    step("R11", 1, 3'd0, 6'h10, 7'h20, 7'h7E, 4'h0, 7'h0, 0);
    // mixed sequences
    for (int i = 0; i < 1500; i++)
      step("R6", ($urandom % 8) != 0, 3'($urandom), 6'($urandom), 7'($urandom),
           (($urandom % 5) == 0) ? 7'h7E : 7'($urandom), 4'($urandom), 7'($urandom), int'($urandom));
    // R9 frame exhaustion
    do_reset();
    step("R12", 1, 3'd0, 6'h27, 7'h1F, 7'h2F, 4'h3, 7'h0, 0);
    for (int i = 0; i < NF - 1; i++)
      step("R5", 1, 3'd1, 6'h00, 7'h00, 7'h00, 4'h0, 7'h0, 0);
    step("R9", 1, 3'd1, 6'h00, 7'h00, 7'h00, 4'h0, 7'h0, 0);
    step("R9", 1, 3'd3, 6'h00, 7'h00, 7'h00, 4'h0, 7'h0, 0);
    step("R11", 1, 3'd0, 6'h00, 7'h10, 7'h20, 4'h0, 7'h0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule